// File: doc/BRIEF.md
# Chip-Enable Framed Serial Command Receiver

This block takes command frames from a host controller over three wires (a chip-enable line, a serial clock and a serial data line) and hands each accepted frame to the command logic as one parallel word. The host first clocks an 8-bit device address while chip enable is low. It then raises chip enable and clocks a data phase of up to 64 bits. When chip enable falls, the frame is closed. The block runs entirely in the system clock domain. It passes the three pins through synchronisers and detects the serial clock and chip-enable edges by oversampling them, so the serial clock may idle either low or high.

A frame is accepted only if the address equals the device address and the number of data bits is one of the legal frame lengths. An accepted frame is presented right-aligned in a 64-bit word: a short frame fills the high-numbered positions and its first bit sits lowest. The word is presented together with its length and a one-cycle valid strobe. Any other frame is discarded with a one-cycle error strobe. Decoding the command word is left to the block that consumes it.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rstN` is low, all outputs are zero and activity on the serial pins has no effect. A frame that is interrupted by reset is neither presented nor reported as an error.
- R2: The address is formed from the last 8 bits clocked while chip enable is low, least significant bit first. A frame is accepted only if that value equals 47h and at least 8 address bits were clocked since the previous chip-enable fall.
- R3: Each data bit is sampled on a rising edge of the serial clock while chip enable is high. After N bits, the first bit received sits at word position 64-N and the last at position 63.
- R4: The legal data lengths are exactly 8, 16, 24 and 64 bits, and `frameLen` reports the length of the presented frame.
- R5: A frame is committed only when chip enable falls. `frameValid` is high for exactly one cycle, and `frameData` and `frameLen` hold their values until the next commit.
- R6: A frame with a wrong address, too few address bits, or a data length outside the legal set (including 0 bits and more than 64 bits) raises `frameErr` for one cycle and leaves `frameData` and `frameLen` unchanged.
- R7: The block works with the serial clock idling low or idling high. For the first three system cycles after reset release, pin levels are only observed and not treated as edges.
- R8: `frameValid` rises on the second system clock edge after the edge that first samples chip enable low.
- R9: `frameValid` and `frameErr` are never high in the same cycle.
- R10: In a presented frame of N < 64 bits, word positions 0 to 63-N are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; blocks transfers while low |
| serCe | input | 1 | Chip-enable pin from the host |
| serClk | input | 1 | Serial clock pin from the host |
| serDat | input | 1 | Serial data pin from the host |
| frameValid | output | 1 | One-cycle strobe: an accepted frame is presented |
| frameErr | output | 1 | One-cycle strobe: a frame was discarded |
| frameData | output | DATA_W | Right-aligned frame bits, first received bit lowest |
| frameLen | output | $clog2(DATA_W+1) | Number of data bits in the presented frame |

## Verification
The bench builds the block with its defaults: a 64-bit data word, an 8-bit address of 47h and two synchroniser stages. With this word width, all four legal lengths and the 65-bit overflow case can be driven directly. The two-stage synchroniser fixes the commit latency at a value that can be sampled exactly. An untimed behavioural model sees the pins through the same three-sample delay and is compared with the outputs every cycle. Directed frames cover both serial clock idle levels, padded and short addresses, illegal lengths, and a reset that cuts a frame in the middle.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Data lengths that close a frame successfully
  localparam int NUM_LENS = 4;
  localparam int LEGAL_LENS [NUM_LENS] = '{8, 16, 24, 64};

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic clrData;
    logic commit;
    logic reject;
  } ctrlStrb_t;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 64,
  parameter int SYNC_STAGES = 2,
  parameter int DCNT_W      = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceSync,
  input  logic              clkSync,
  input  logic              addrMatch,
  output ctrlStrb_t         strb,
  output logic [DCNT_W-1:0] dataCnt
);

  localparam int ACNT_W = $clog2(ADDR_W + 1);
  localparam int WARM_W = $clog2(SYNC_STAGES + 2);
  localparam logic [ACNT_W-1:0] ADDR_FULL = ACNT_W'(ADDR_W);
  localparam logic [DCNT_W-1:0] DATA_CAP  = DCNT_W'(DATA_W + 1);
  localparam logic [WARM_W-1:0] WARM_END  = WARM_W'(SYNC_STAGES + 1);

  logic [WARM_W-1:0] warmCnt;
  logic              armed;
  logic              ceQ;
  logic              clkQ;
  logic              ceRise;
  logic              ceFall;
  logic              clkRise;
  logic [ACNT_W-1:0] addrCnt;
  logic [NUM_LENS-1:0] lenHit;
  logic              lenOk;
  logic              frameOk;

  // Pin history must be primed before any change counts as an edge
  assign armed = (warmCnt == WARM_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
      ceQ     <= 1'b0;
      clkQ    <= 1'b0;
    end else begin
      if (!armed) warmCnt <= warmCnt + 1'b1;
      ceQ  <= ceSync;
      clkQ <= clkSync;
    end
  end

  assign ceRise  = armed &  ceSync & ~ceQ;
  assign ceFall  = armed & ~ceSync &  ceQ;
  // A chip-enable edge wins over a coincident serial clock edge
  assign clkRise = armed & clkSync & ~clkQ & ~ceRise & ~ceFall;

  for (genvar g = 0; g < NUM_LENS; g++) begin : g_len
    assign lenHit[g] = (dataCnt == DCNT_W'(LEGAL_LENS[g]));
  end

  assign lenOk   = |lenHit;
  assign frameOk = (addrCnt == ADDR_FULL) & addrMatch & lenOk;

  always_comb begin
    strb           = '0;
    strb.shiftAddr = clkRise & ~ceSync;
    strb.shiftData = clkRise &  ceSync;
    strb.clrData   = ceRise;
    strb.commit    = ceFall &  frameOk;
    strb.reject    = ceFall & ~frameOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
      dataCnt <= '0;
    end else begin
      if (ceFall) addrCnt <= '0;
      else if (strb.shiftAddr && addrCnt != ADDR_FULL) addrCnt <= addrCnt + 1'b1;

      if (ceRise) dataCnt <= '0;
      else if (strb.shiftData && dataCnt != DATA_CAP) dataCnt <= dataCnt + 1'b1;
    end
  end

  a_r4_count_restarts: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrData |=> (dataCnt == '0));

  a_r2_addr_count_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit || strb.reject) |=> (addrCnt == '0));

endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 64,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 'h47,
  parameter int                DCNT_W   = $clog2(DATA_W + 2),
  parameter int                LEN_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              serBit,
  input  logic [DCNT_W-1:0] dataCnt,
  output logic              addrMatch,
  output logic [DATA_W-1:0] frameData,
  output logic [LEN_W-1:0]  frameLen,
  output logic              frameValid,
  output logic              frameErr
);

  logic [ADDR_W-1:0] addrSr;
  logic [DATA_W-1:0] dataSr;

  assign addrMatch = (addrSr == DEV_ADDR);

  // Both shift registers fill from the top, so the first bit ends lowest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSr <= '0;
      dataSr <= '0;
    end else begin
      if (strb.shiftAddr) addrSr <= {serBit, addrSr[ADDR_W-1:1]};
      if (strb.clrData) dataSr <= '0;
      else if (strb.shiftData) dataSr <= {serBit, dataSr[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameData  <= '0;
      frameLen   <= '0;
      frameValid <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      frameValid <= strb.commit;
      frameErr   <= strb.reject;
      if (strb.commit) begin
        frameData <= dataSr;
        frameLen  <= LEN_W'(dataCnt);
      end
    end
  end

  a_r9_outcome_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(frameValid && frameErr));

  a_r5_valid_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  a_r5_hold_between_commits: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> ($stable(frameData) && $stable(frameLen)));

  a_r6_reject_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> ($stable(frameData) && $stable(frameLen)));

  a_r10_low_positions_clear: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && (frameLen < LEN_W'(DATA_W))) |-> ((frameData << frameLen) == '0));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 64,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 'h47,
  parameter int                SYNC_STAGES = 2,
  localparam int               LEN_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serCe,
  input  logic              serClk,
  input  logic              serDat,
  output logic              frameValid,
  output logic              frameErr,
  output logic [DATA_W-1:0] frameData,
  output logic [LEN_W-1:0]  frameLen
);

  localparam int DCNT_W = $clog2(DATA_W + 2);

  logic [2:0]          pinSync;
  sfr_pkg::ctrlStrb_t  strb;
  logic [DCNT_W-1:0]   dataCnt;
  logic                addrMatch;

  sfr_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serDat, serClk, serCe}),
    .syncOut (pinSync)
  );

  sfr_ctrl #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .DCNT_W      (DCNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceSync    (pinSync[0]),
    .clkSync   (pinSync[1]),
    .addrMatch (addrMatch),
    .strb      (strb),
    .dataCnt   (dataCnt)
  );

  sfr_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR),
    .DCNT_W   (DCNT_W),
    .LEN_W    (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .serBit     (pinSync[2]),
    .dataCnt    (dataCnt),
    .addrMatch  (addrMatch),
    .frameData  (frameData),
    .frameLen   (frameLen),
    .frameValid (frameValid),
    .frameErr   (frameErr)
  );

endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceP = 1'b0;
  logic        clkP = 1'b0;
  logic        datP = 1'b0;
  logic        frameValid;
  logic        frameErr;
  logic [63:0] frameData;
  logic [6:0]  frameLen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit idleHi = 1'b0;
  int validSeen = 0;
  int errSeen = 0;
  logic [63:0] lastData = '0;
  int lastLen = 0;

  always #10 clk = ~clk;

  serial_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .serCe(ceP), .serClk(clkP), .serDat(datP),
    .frameValid(frameValid), .frameErr(frameErr), .frameData(frameData), .frameLen(frameLen)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: pins seen three samples late, events applied per edge
  typedef struct packed { logic ce; logic sc; logic sd; } pins_t;
  pins_t hist[$];
  int mA = 0, mD = 0;
  logic [7:0]  mAddr = '0;
  logic [63:0] mDv = '0;
  logic mValid = 0, mErr = 0;
  logic [63:0] mData = '0;
  int mLen = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      hist.delete();
      mA = 0; mD = 0; mAddr = '0; mDv = '0;
      mValid = 0; mErr = 0; mData = '0; mLen = 0;
    end else begin
      mValid = 0; mErr = 0;
      if (hist.size() >= 3) begin
        pins_t cur, old;
        cur = hist[1];
        old = hist[2];
        if (old.ce && !cur.ce) begin
          if (mA >= 8 && mAddr == 8'h47 && (mD == 8 || mD == 16 || mD == 24 || mD == 64)) begin
            mValid = 1; mData = mDv; mLen = mD;
          end else mErr = 1;
          mA = 0;
        end else if (!old.ce && cur.ce) begin
          mD = 0; mDv = '0;
        end else if (!old.sc && cur.sc) begin
          if (cur.ce) begin
            mDv = {cur.sd, mDv[63:1]};
            if (mD < 65) mD++;
          end else begin
            mAddr = {cur.sd, mAddr[7:1]};
            if (mA < 8) mA++;
          end
        end
      end
      hist.push_front('{ce: ceP, sc: clkP, sd: datP});
      if (hist.size() > 3) void'(hist.pop_back());
    end
  end

  // Compare a quarter period after each rising edge
  always begin
    @(posedge clk);
    #5;
    if (rstN && !done) begin
      chk(frameValid === mValid, "R5 valid strobe vs model", 64'(frameValid), 64'(mValid));
      chk(frameErr === mErr, "R6 error strobe vs model", 64'(frameErr), 64'(mErr));
      chk(frameData === mData, "R3 frame word vs model", frameData, mData);
      chk(int'(frameLen) == mLen, "R4 length vs model", 64'(frameLen), 64'(mLen));
      chk(!(frameValid && frameErr), "R9 strobes exclusive", {frameValid, frameErr}, 64'd0);
      if (frameValid) begin validSeen++; lastData = frameData; lastLen = int'(frameLen); end
      if (frameErr) errSeen++;
    end
  end

  task automatic pulseBit(input logic b);
    if (idleHi) begin
      clkP = 1'b0; datP = b;
      repeat (3) @(negedge clk);
      clkP = 1'b1;
      repeat (3) @(negedge clk);
    end else begin
      datP = b;
      repeat (3) @(negedge clk);
      clkP = 1'b1;
      repeat (3) @(negedge clk);
      clkP = 1'b0;
    end
  endtask

  task automatic sendHead(input logic [15:0] av, input int nA);
    ceP = 1'b0; clkP = idleHi;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nA; i++) pulseBit(av[i]);
    repeat (4) @(negedge clk);
    ceP = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendData(input logic [71:0] d, input int nD);
    for (int i = 0; i < nD; i++) pulseBit(d[i]);
  endtask

  task automatic xfer(input logic [15:0] av, input int nA, input logic [71:0] d, input int nD);
    sendHead(av, nA);
    sendData(d, nD);
    repeat (4) @(negedge clk);
    ceP = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
      finishRun();
    end
  end

  initial begin
    int v0, e0;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(frameValid == 0 && frameErr == 0, "R1 strobes low in reset", {frameValid, frameErr}, 64'd0);
    chk(frameData == '0, "R1 word zero in reset", frameData, 64'd0);
    chk(frameLen == '0, "R1 length zero in reset", 64'(frameLen), 64'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4: full 64-bit frame, first bit lowest
    v0 = validSeen;
    xfer(16'h0047, 8, {8'h00, 64'hF00D_CAFE_1234_8A51}, 64);
    chk(validSeen == v0 + 1, "R5 one commit per frame", 64'(validSeen - v0), 64'd1);
    chk(lastData == 64'hF00D_CAFE_1234_8A51, "R3 64-bit word order", lastData, 64'hF00D_CAFE_1234_8A51);
    chk(lastLen == 64, "R4 length 64", 64'(lastLen), 64'd64);

    // R3 R10: 24-bit frame lands in the top positions
    xfer(16'h0047, 8, 72'h00_00A5C3E1 & 72'hFFFFFF, 24);
    chk(lastData == {24'hA5C3E1, 40'd0}, "R10 24-bit right-aligned", lastData, {24'hA5C3E1, 40'd0});
    chk(lastLen == 24, "R4 length 24", 64'(lastLen), 64'd24);

    // R7: serial clock idling high, 16 and 8 bits
    idleHi = 1'b1;
    xfer(16'h0047, 8, 72'h3C96, 16);
    chk(lastData == {16'h3C96, 48'd0}, "R7 16-bit with high idle", lastData, {16'h3C96, 48'd0});
    chk(lastLen == 16, "R4 length 16", 64'(lastLen), 64'd16);
    xfer(16'h0047, 8, 72'h5B, 8);
    chk(lastData == {8'h5B, 56'd0}, "R7 8-bit with high idle", lastData, {8'h5B, 56'd0});
    idleHi = 1'b0;

    // R2: padded address keeps the last eight bits
    xfer(16'h008F, 9, 72'hC3, 8);
    chk(lastData == {8'hC3, 56'd0}, "R2 nine address bits accepted", lastData, {8'hC3, 56'd0});

    // R2 R6: wrong address, short address
    held = lastData;
    v0 = validSeen; e0 = errSeen;
    xfer(16'h0046, 8, 72'hFF, 8);
    xfer(16'h0047, 7, 72'hFF, 8);
    chk(errSeen == e0 + 2 && validSeen == v0, "R2 bad address rejected", 64'(errSeen - e0), 64'd2);
    chk(frameData == held, "R6 word kept after reject", frameData, held);

    // R4 R6: illegal lengths 12, 0 and 65
    e0 = errSeen;
    xfer(16'h0047, 8, 72'hABC, 12);
    xfer(16'h0047, 8, 72'h0, 0);
    xfer(16'h0047, 8, {8'h01, 64'hFFFF_FFFF_FFFF_FFFF}, 65);
    chk(errSeen == e0 + 3 && validSeen == v0, "R4 illegal lengths rejected", 64'(errSeen - e0), 64'd3);
    chk(int'(frameLen) == 8, "R6 length kept after reject", 64'(frameLen), 64'd8);

    // R8: commit latency from chip-enable fall
    sendHead(16'h0047, 8);
    sendData(72'h1E2D, 16);
    repeat (4) @(negedge clk);
    ceP = 1'b0;
    @(negedge clk);
    chk(frameValid == 0, "R8 no strobe one edge after", 64'(frameValid), 64'd0);
    @(negedge clk);
    chk(frameValid == 0, "R8 no strobe two edges after", 64'(frameValid), 64'd0);
    @(negedge clk);
    chk(frameValid == 1, "R8 strobe on second edge after sampling", 64'(frameValid), 64'd1);
    repeat (6) @(negedge clk);

    // R1: reset in the middle of a frame
    v0 = validSeen; e0 = errSeen;
    sendHead(16'h0047, 8);
    sendData(72'h3FF, 10);
    rstN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      clkP = ~clkP; datP = ~datP;
      repeat (3) @(negedge clk);
    end
    ceP = 1'b0; clkP = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    chk(validSeen == v0 && errSeen == e0, "R1 cut frame dropped", 64'(validSeen + errSeen), 64'(v0 + e0));
    chk(frameData == '0, "R1 word cleared by reset", frameData, 64'd0);

    // R7: pins held high across reset release produce no event
    rstN = 1'b0;
    ceP = 1'b1; clkP = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    chk(validSeen == v0 && errSeen == e0, "R7 no edge at warm-up", 64'(validSeen + errSeen), 64'(v0 + e0));
    ceP = 1'b0; clkP = 1'b0;
    repeat (8) @(negedge clk);

    // Recovery after reset
    xfer(16'h0047, 8, 72'h96, 8);
    chk(lastData == {8'h96, 56'd0}, "R3 frame after reset", lastData, {8'h96, 56'd0});

    finishRun();
  end

endmodule